// File: doc/BRIEF.md
# Channel Status Readout Unit

This block reports one flag per voice channel to a host controller. Each channel supplies two flags: a ready flag, which is high when the channel can take new writes, and an active-low busy flag, which is low while the channel is producing audio. A select input chooses which of the two sets is reported. The chosen set forms a status byte in which bit k belongs to channel k+1. That byte reaches the host over three paths.

In bus mode, the byte is placed on a parallel data bus for as long as the read strobe stays low. In serial mode, the byte is shifted out one bit at a time, highest channel first, and each rising edge of the host's serial clock moves to the next bit. Four status lines run alongside these paths and always show the live flags of one half of the channels. A nibble-select input picks the half.

The byte for the parallel and serial paths is captured when the read strobe falls. A read therefore returns a single consistent snapshot even if the flags change during the read. All host inputs are sampled on the block clock.

Top module: `chan_stat_rd`

## Requirements
- R1: When `src_sel` is 1 the ready flags (`ncr_i`) form the status byte; when it is 0 the busy flags (`busy_i`) form it. This holds for the parallel, serial and nibble paths.
- R2: Bit k of the status byte (and of `bus_data`) belongs to channel k+1, so bit 7 is channel 8 and bit 0 is channel 1.
- R3: With `ser_mode`=0, one clock after `rd_n` is sampled low, `bus_oe` is 1 and `bus_data` holds the status byte. One clock after `rd_n` is sampled high, `bus_oe` is 0 and `bus_data` is 0.
- R4: The byte is captured at the first clock edge at which `rd_n` is sampled low. Flag changes after that edge leave `bus_data` and the serial bits unchanged until `rd_n` returns high.
- R5: With `ser_mode`=1, `cs_n`=0 and `rd_n` low, `ser_out` shows bit 7 of the captured byte first. After the k-th sampled rising edge of `sclk` it shows bit 7-k. After 8 edges it is 0.
- R6: Whenever `rd_n` or `cs_n` is sampled high, the serial position returns to bit 7. `ser_out` is 0 while `cs_n` is high, and also one clock after `rd_n` is sampled high.
- R7: One clock after the inputs change, `nib_out[3:0]` shows the status bits of channels 4..1 when `nib_sel`=0 and channels 8..5 when `nib_sel`=1. Line 3 carries the highest channel of the group.
- R8: While `ser_mode`=1, `bus_oe` stays 0.
- R9: During reset, `bus_oe`, `bus_data`, `ser_out` and `nib_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ser_mode | input | 1 | 1 selects the serial path, 0 the parallel bus |
| src_sel | input | 1 | 1 reports ready flags, 0 reports busy flags |
| ncr_i | input | NCH | Per-channel ready flags |
| busy_i | input | NCH | Per-channel busy flags, low while playing |
| rd_n | input | 1 | Read strobe, active low |
| cs_n | input | 1 | Serial chip select, active low |
| sclk | input | 1 | Serial shift clock from the host |
| nib_sel | input | SEL_W | Chooses the channel group shown on `nib_out` |
| bus_data | output | NCH | Parallel status byte, 0 when not driven |
| bus_oe | output | 1 | Output enable for the parallel bus |
| ser_out | output | 1 | Serial status bit |
| nib_out | output | GRP_W | Live status of the selected channel group |

## Verification
The bench builds the block with its default values: eight channels in two groups of four, which makes `nib_sel` a single bit. That size is small enough to sweep all 256 flag patterns through each path.

Each pattern goes through a full parallel read and a full nine-step serial shift, with the source select toggled between reads, and through both nibble views. The flags are inverted in the middle of every read, which exercises snapshot stability on every pattern. Serial reads also deassert chip select partway through, to check that the bit position returns to the top.

// File: rtl/chan_stat_pkg.sv
package chan_stat_pkg;

   typedef enum logic {
      SRC_BUSY = 1'b0,
      SRC_NCR  = 1'b1
   } src_e;

   function automatic int sel_width(input int ngrp);
      return (ngrp > 1) ? $clog2(ngrp) : 1;
   endfunction

endpackage

// File: rtl/chan_stat_srcmux.sv
module chan_stat_srcmux #(
   parameter int NCH = 8
) (
   input  logic           src_sel,
   input  logic [NCH-1:0] ncr_i,
   input  logic [NCH-1:0] busy_i,
   output logic [NCH-1:0] stat_o
);
   import chan_stat_pkg::*;

   always_comb begin
      if (src_e'(src_sel) == SRC_NCR) stat_o = ncr_i;
      else                            stat_o = busy_i;
   end
endmodule

// File: rtl/chan_stat_capture.sv
module chan_stat_capture #(
   parameter int NCH = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           rd_n,
   input  logic [NCH-1:0] stat_i,
   output logic           rd_q_o,
   output logic [NCH-1:0] snap_o
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_q_o <= 1'b1;
         snap_o <= '0;
      end else begin
         rd_q_o <= rd_n;
         if (rd_q_o && !rd_n) snap_o <= stat_i;
      end
   end
endmodule

// File: rtl/chan_stat_par.sv
module chan_stat_par #(
   parameter int NCH = 8
) (
   input  logic           ser_mode,
   input  logic           rd_q,
   input  logic [NCH-1:0] snap,
   output logic           bus_oe,
   output logic [NCH-1:0] bus_data
);
   always_comb begin
      bus_oe   = !ser_mode && !rd_q;
      bus_data = bus_oe ? snap : '0;
   end
endmodule

// File: rtl/chan_stat_ser.sv
module chan_stat_ser #(
   parameter int NCH = 8
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           ser_mode,
   input  logic           cs_n,
   input  logic           rd_n,
   input  logic           rd_q,
   input  logic           sclk,
   input  logic [NCH-1:0] snap,
   output logic           ser_out
);
   localparam int CW = $clog2(NCH + 1);

   logic          sclk_q;
   logic [CW-1:0] pos;
   logic          bit_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= 1'b0;
         pos    <= '0;
      end else begin
         sclk_q <= sclk;
         if (rd_n || cs_n)
            pos <= '0;
         else if (sclk && !sclk_q && (pos < CW'(NCH)))
            pos <= pos + 1'b1;
      end
   end

   always_comb begin
      bit_v = 1'b0;
      for (int i = 0; i < NCH; i++)
         if (pos == CW'(NCH - 1 - i)) bit_v = snap[i];
   end

   assign ser_out = ser_mode && !cs_n && !rd_q && bit_v;
endmodule

// File: rtl/chan_stat_nib.sv
module chan_stat_nib #(
   parameter int NCH   = 8,
   parameter int GRP_W = 4,
   parameter int SEL_W = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEL_W-1:0] nib_sel,
   input  logic [NCH-1:0]   stat_i,
   output logic [GRP_W-1:0] nib_out
);
   localparam int NGRP = NCH / GRP_W;

   logic [GRP_W-1:0] pick;

   generate
      if (NGRP == 1) begin : g_single
         logic unused_sel;
         assign unused_sel = ^nib_sel;
         assign pick = stat_i[GRP_W-1:0];
      end else begin : g_multi
         always_comb begin
            pick = '0;
            for (int g = 0; g < NGRP; g++)
               if (nib_sel == SEL_W'(g)) pick = stat_i[g*GRP_W +: GRP_W];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) nib_out <= '0;
      else        nib_out <= pick;
   end
endmodule

// File: rtl/chan_stat_rd.sv
module chan_stat_rd #(
   parameter int NCH   = 8,
   parameter int GRP_W = 4,
   localparam int SEL_W = chan_stat_pkg::sel_width(NCH / GRP_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ser_mode,
   input  logic             src_sel,
   input  logic [NCH-1:0]   ncr_i,
   input  logic [NCH-1:0]   busy_i,
   input  logic             rd_n,
   input  logic             cs_n,
   input  logic             sclk,
   input  logic [SEL_W-1:0] nib_sel,
   output logic [NCH-1:0]   bus_data,
   output logic             bus_oe,
   output logic             ser_out,
   output logic [GRP_W-1:0] nib_out
);
   generate
      if (NCH < 1) begin : g_bad_nch
         $error("NCH must be at least 1");
      end
      if (GRP_W < 1 || (NCH % GRP_W) != 0) begin : g_bad_grp
         $error("GRP_W must divide NCH");
      end
   endgenerate

   logic [NCH-1:0] stat;
   logic [NCH-1:0] snap;
   logic           rd_q;

   chan_stat_srcmux #(.NCH(NCH)) u_mux (
      .src_sel (src_sel),
      .ncr_i   (ncr_i),
      .busy_i  (busy_i),
      .stat_o  (stat)
   );

   chan_stat_capture #(.NCH(NCH)) u_cap (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_n   (rd_n),
      .stat_i (stat),
      .rd_q_o (rd_q),
      .snap_o (snap)
   );

   chan_stat_par #(.NCH(NCH)) u_par (
      .ser_mode (ser_mode),
      .rd_q     (rd_q),
      .snap     (snap),
      .bus_oe   (bus_oe),
      .bus_data (bus_data)
   );

   chan_stat_ser #(.NCH(NCH)) u_ser (
      .clk      (clk),
      .rst_n    (rst_n),
      .ser_mode (ser_mode),
      .cs_n     (cs_n),
      .rd_n     (rd_n),
      .rd_q     (rd_q),
      .sclk     (sclk),
      .snap     (snap),
      .ser_out  (ser_out)
   );

   chan_stat_nib #(.NCH(NCH), .GRP_W(GRP_W), .SEL_W(SEL_W)) u_nib (
      .clk     (clk),
      .rst_n   (rst_n),
      .nib_sel (nib_sel),
      .stat_i  (stat),
      .nib_out (nib_out)
   );
endmodule

// File: rtl/chan_stat_chk.sv
module chan_stat_chk #(
   parameter int NCH   = 8,
   parameter int GRP_W = 4,
   parameter int SEL_W = 1
) (
   input logic             clk,
   input logic             rst_n,
   input logic             ser_mode,
   input logic             src_sel,
   input logic [NCH-1:0]   ncr_i,
   input logic [NCH-1:0]   busy_i,
   input logic             rd_n,
   input logic             cs_n,
   input logic [SEL_W-1:0] nib_sel,
   input logic [NCH-1:0]   bus_data,
   input logic             bus_oe,
   input logic             ser_out,
   input logic [GRP_W-1:0] nib_out
);
   // R4: snapshot holds while the bus stays enabled
   a_r4_snap_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_oe && $past(bus_oe)) |-> $stable(bus_data));

   // R3: bus released once the strobe has been high for a cycle
   a_r3_bus_release: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_n && $past(rd_n)) |-> (!bus_oe && bus_data == '0));

   // R6: serial line quiet with chip select high or strobe previously high
   a_r6_ser_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (cs_n || $past(rd_n)) |-> !ser_out);

   // R8: the two read paths never both active
   a_r8_path_excl: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_mode && $past(ser_mode)) |-> !bus_oe);

   // R7: nibble view settles when its inputs do not move
   a_r7_nib_steady: assert property (@(posedge clk) disable iff (!rst_n)
      ($stable(ncr_i) && $stable(busy_i) && $stable(src_sel) && $stable(nib_sel))
      |=> $stable(nib_out));
endmodule

bind chan_stat_rd chan_stat_chk #(.NCH(NCH), .GRP_W(GRP_W), .SEL_W(SEL_W)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ser_mode (ser_mode),
   .src_sel  (src_sel),
   .ncr_i    (ncr_i),
   .busy_i   (busy_i),
   .rd_n     (rd_n),
   .cs_n     (cs_n),
   .nib_sel  (nib_sel),
   .bus_data (bus_data),
   .bus_oe   (bus_oe),
   .ser_out  (ser_out),
   .nib_out  (nib_out)
);

// File: tb/chan_stat_rd_tb.sv
module chan_stat_rd_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ser_mode = 1'b0;
   logic       src_sel = 1'b0;
   logic [7:0] ncr_i = '0;
   logic [7:0] busy_i = '0;
   logic       rd_n = 1'b1;
   logic       cs_n = 1'b1;
   logic       sclk = 1'b0;
   logic [0:0] nib_sel = '0;
   logic [7:0] bus_data;
   logic       bus_oe;
   logic       ser_out;
   logic [3:0] nib_out;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   chan_stat_rd u_dut (
      .clk(clk), .rst_n(rst_n), .ser_mode(ser_mode), .src_sel(src_sel),
      .ncr_i(ncr_i), .busy_i(busy_i), .rd_n(rd_n), .cs_n(cs_n), .sclk(sclk),
      .nib_sel(nib_sel), .bus_data(bus_data), .bus_oe(bus_oe),
      .ser_out(ser_out), .nib_out(nib_out)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   function automatic logic [7:0] pick(input logic s, input logic [7:0] r, input logic [7:0] b);
      return s ? r : b;
   endfunction

   // R1 R2 R3 R4: parallel read, flags inverted mid-read
   task automatic par_read(input logic [7:0] r, input logic [7:0] b, input logic s);
      logic [7:0] st;
      st = pick(s, r, b);
      @(negedge clk);
      ser_mode = 1'b0; src_sel = s; ncr_i = r; busy_i = b; rd_n = 1'b0;
      @(negedge clk);
      chk("R3 bus_oe on read", 32'(bus_oe), 32'd1);
      chk("R1 R2 bus_data byte", 32'(bus_data), 32'(st));
      ncr_i = ~r; busy_i = ~b;
      @(negedge clk);
      chk("R4 bus_data held", 32'(bus_data), 32'(st));
      rd_n = 1'b1;
      @(negedge clk);
      chk("R3 bus released", {bus_oe, bus_data}, 32'd0);
   endtask

   // R5 R6 R8 R4: serial read with chip select dropout
   task automatic ser_read(input logic [7:0] r, input logic [7:0] b, input logic s);
      logic [7:0] st;
      st = pick(s, r, b);
      @(negedge clk);
      ser_mode = 1'b1; src_sel = s; ncr_i = r; busy_i = b; cs_n = 1'b0; rd_n = 1'b0;
      @(negedge clk);
      chk("R8 no bus in serial", 32'(bus_oe), 32'd0);
      chk("R5 first bit msb", 32'(ser_out), 32'(st[7]));
      ncr_i = ~r; busy_i = ~b;
      for (int k = 1; k <= 8; k++) begin
         sclk = 1'b1;
         @(negedge clk);
         sclk = 1'b0;
         @(negedge clk);
         chk("R5 R4 shifted bit", 32'(ser_out), (k < 8) ? 32'(st[7-k]) : 32'd0);
      end
      cs_n = 1'b1;
      @(negedge clk);
      chk("R6 quiet on cs high", 32'(ser_out), 32'd0);
      cs_n = 1'b0;
      @(negedge clk);
      chk("R6 restart at msb", 32'(ser_out), 32'(st[7]));
      rd_n = 1'b1; cs_n = 1'b1;
      @(negedge clk);
      chk("R6 quiet after read", 32'(ser_out), 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk("R9 reset outputs", {bus_oe, ser_out, bus_data, nib_out}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      for (int p = 0; p < 256; p++) begin
         par_read(8'(p), 8'(p) ^ 8'h3C, 1'b1);
         par_read(8'(p) ^ 8'hC3, 8'(p), 1'b0);
      end
      for (int p = 0; p < 256; p++)
         ser_read(8'(p), ~8'(p), p[0]);
      for (int p = 0; p < 256; p++) begin
         for (int s = 0; s < 2; s++) begin
            logic [7:0] st;
            @(negedge clk);
            ncr_i = 8'(p); busy_i = 8'(p) ^ 8'hA5; src_sel = p[1]; nib_sel = 1'(s);
            st = pick(p[1], 8'(p), 8'(p) ^ 8'hA5);
            @(negedge clk);
            chk("R7 R1 nibble view", 32'(nib_out), (s == 1) ? 32'(st[7:4]) : 32'(st[3:0]));
         end
      end
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog act=running exp=done");
         $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end
endmodule